// File: doc/BRIEF.md
# Audio Sample FIFO With Slot-Aligned Underrun Muting

This block is an eight-word sample buffer placed between a word-wide write/read port (driven by software or a DMA engine) and a serial slot engine. A direction input selects the data flow. In transmit mode the bus side pushes samples and the slot engine pulls one sample per slot strobe. In receive mode the slot engine pushes one captured sample per strobe and the bus side pops them. A programmable fill threshold drives a request output that asks the bus side to refill (transmit) or drain (receive) the buffer. A coarse fill-level code is also reported.

When the slot engine asks for a sample in transmit mode and the buffer is empty, the block outputs zero and records the index of the slot that went unserved. It then keeps sending zero until the buffer holds data again *and* the recorded slot index comes round once more. The next stored sample is therefore always placed in the slot it was meant for. A receive-mode sample that arrives while the buffer is full is dropped. Both error conditions raise sticky flags, which are cleared by a write-one-to-clear input. A flush input empties the buffer at once.

Top module: `audio_sample_fifo`

## Requirements
- R1: The buffer holds up to 8 words. Words leave in the order they entered: in transmit mode (`dir_rx_i`=0) words written on `wr_en_i` appear on `slot_data_o` during successive `slot_req_i` strobes.
- R2: `level_o` encodes the stored word count as follows: 0 gives 3'd0; 1–2 give 3'd1; 3–4 give 3'd2; 5–6 give 3'd3; 7 gives 3'd4; 8 gives 3'd5. It updates the cycle after a push or pop.
- R3: `thresh_i` selects a threshold of 0, 2, 4, 6 or 8 words for codes 3'd0 to 3'd4; codes 3'd5 to 3'd7 act as 8. In transmit mode `req_o` is high when count ≤ threshold and the buffer is not full.
- R4: In receive mode `req_o` is high when count ≥ threshold and the buffer is not empty.
- R5: A transmit-mode write while the buffer is full is ignored and leaves the stored words unchanged.
- R6: In receive mode `rd_data_o` shows the oldest word while `rd_en_i` pops it. A read while empty returns 0 and leaves the count at 0.
- R7: A transmit slot strobe while the buffer is empty outputs 0, records `slot_idx_i`, and sets the sticky underrun flag `udr_o`.
- R8: After an underrun every slot strobe outputs 0 and pops nothing until the buffer is non-empty and `slot_idx_i` equals the recorded index. That strobe outputs the oldest word and ends muting.
- R9: A receive slot strobe while full discards `slot_data_i` and sets the sticky overrun flag `ovr_o`.
- R10: `flush_i` empties the buffer in the next cycle and takes priority over a simultaneous push or pop. Flushed words are never output.
- R11: `err_clr_i[0]` clears `ovr_o` and `err_clr_i[1]` clears `udr_o`. A clear wins over a set in the same cycle. Flags otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dir_rx_i | input | 1 | 0 transmit, 1 receive |
| thresh_i | input | 3 | Request threshold code |
| flush_i | input | 1 | Empty the buffer |
| wr_en_i | input | 1 | Bus write strobe (transmit) |
| wr_data_i | input | DW | Bus write word |
| rd_en_i | input | 1 | Bus read strobe (receive) |
| rd_data_o | output | DW | Bus read word |
| slot_req_i | input | 1 | Slot strobe from the serial engine |
| slot_idx_i | input | SW | Index of the current slot |
| slot_data_i | input | DW | Captured word (receive) |
| slot_data_o | output | DW | Word for the current slot (transmit) |
| level_o | output | 3 | Fill-level code |
| req_o | output | 1 | Refill/drain request |
| ovr_o | output | 1 | Sticky overrun flag |
| udr_o | output | 1 | Sticky underrun flag |
| err_clr_i | input | 2 | Write-one-to-clear for flags |

## Verification
A full eight-word transmit fill with one extra write separates correct ordering and level coding from a pointer that wraps onto stored data. An underrun sequence in which a refill word arrives while slot indices other than the missed one go by shows whether the design waits for the recorded slot or releases the word too early. A receive fill past full, followed by a complete drain, shows that the overflowing word is dropped rather than overwriting the oldest one. Threshold sweeps in both directions and a flush followed by fresh data separate the two request rules and confirm that flushed words never reappear.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  typedef enum logic [2:0] {
    LVL_EMPTY = 3'd0,
    LVL_Q1    = 3'd1,
    LVL_Q2    = 3'd2,
    LVL_Q3    = 3'd3,
    LVL_PART  = 3'd4,
    LVL_FULL  = 3'd5
  } lvl_e;

  function automatic lvl_e lvl_code(input int unsigned cnt, input int unsigned depth);
    int unsigned q;
    q = depth / 4;
    if (cnt == 0)            return LVL_EMPTY;
    else if (cnt >= depth)   return LVL_FULL;
    else if (cnt <= q)       return LVL_Q1;
    else if (cnt <= 2 * q)   return LVL_Q2;
    else if (cnt <= 3 * q)   return LVL_Q3;
    else                     return LVL_PART;
  endfunction

  function automatic int unsigned thr_words(input logic [2:0] code, input int unsigned depth);
    if (code >= 3'd4) return depth;
    return 32'(code) * (depth / 4);
  endfunction
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= nxt(wptr_q);
      if (pop_i)  rptr_q <= nxt(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/afifo_mute.sv
module afifo_mute #(
  parameter int unsigned SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          empty_i,
  input  logic [SW-1:0] idx_i,
  output logic          serve_o,
  output logic          udr_evt_o
);
  logic          muting_q;
  logic [SW-1:0] miss_q;
  logic          hit;

  // while muting, only the recorded slot may take data
  assign hit       = !empty_i && (!muting_q || (idx_i == miss_q));
  assign serve_o   = req_i && hit;
  assign udr_evt_o = req_i && !muting_q && empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      muting_q <= 1'b0;
      miss_q   <= '0;
    end else if (udr_evt_o) begin
      muting_q <= 1'b1;
      miss_q   <= idx_i;
    end else if (serve_o) begin
      muting_q <= 1'b0;
    end
  end
endmodule

// File: rtl/afifo_flags.sv
module afifo_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (clr_i[g]) q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
  import audio_fifo_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,   // multiple of 4
  parameter int unsigned SW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_rx_i,
  input  logic [2:0]    thresh_i,
  input  logic          flush_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          slot_req_i,
  input  logic [SW-1:0] slot_idx_i,
  input  logic [DW-1:0] slot_data_i,
  output logic [DW-1:0] slot_data_o,
  output logic [2:0]    level_o,
  output logic          req_o,
  output logic          ovr_o,
  output logic          udr_o,
  input  logic [1:0]    err_clr_i
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic [DW-1:0] head, din;
  logic          full, empty, push, pop, serve, udr_evt, ovr_evt, tx;
  logic [1:0]    flags;
  int unsigned   thr;

  assign tx    = !dir_rx_i;
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assign push    = tx ? (wr_en_i && !full) : (slot_req_i && !full);
  assign pop     = tx ? serve : (rd_en_i && !empty);
  assign din     = tx ? wr_data_i : slot_data_i;
  assign ovr_evt = dir_rx_i && slot_req_i && full;

  afifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (din),
    .head_o  (head),
    .count_o (count)
  );

  afifo_mute #(.SW(SW)) u_mute (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (slot_req_i && tx),
    .empty_i   (empty),
    .idx_i     (slot_idx_i),
    .serve_o   (serve),
    .udr_evt_o (udr_evt)
  );

  afifo_flags #(.N(2)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({udr_evt, ovr_evt}),
    .clr_i  (err_clr_i),
    .q_o    (flags)
  );

  assign ovr_o = flags[0];
  assign udr_o = flags[1];

  assign thr         = thr_words(thresh_i, DEPTH);
  assign level_o     = lvl_code(32'(count), DEPTH);
  assign req_o       = tx ? ((32'(count) <= thr) && !full)
                          : ((32'(count) >= thr) && !empty);
  assign slot_data_o = serve ? head : '0;
  assign rd_data_o   = (dir_rx_i && !empty) ? head : '0;
endmodule

// File: rtl/afifo_chk.sv
module afifo_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dir_rx_i,
  input logic          flush_i,
  input logic          wr_en_i,
  input logic          slot_req_i,
  input logic [1:0]    err_clr_i,
  input logic [DW-1:0] slot_data_o,
  input logic [DW-1:0] rd_data_o,
  input logic [2:0]    level_o,
  input logic          req_o,
  input logic          ovr_o,
  input logic          udr_o
);
  assert_level_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= 3'd5);

  assert_tx_full_no_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rx_i && level_o == 3'd5) |-> !req_o);

  assert_rx_empty_no_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rx_i && level_o == 3'd0) |-> !req_o);

  assert_full_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rx_i && level_o == 3'd5 && wr_en_i && !slot_req_i && !flush_i) |=> level_o == 3'd5);

  assert_empty_read_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rx_i && level_o == 3'd0) |-> rd_data_o == '0);

  assert_underrun_mute_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rx_i && level_o == 3'd0 && slot_req_i) |-> slot_data_o == '0);

  assert_udr_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(udr_o) |-> $past(slot_req_i && !dir_rx_i && level_o == 3'd0));

  assert_overrun_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rx_i && level_o == 3'd5 && slot_req_i && !err_clr_i[0]) |=> ovr_o);

  assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> level_o == 3'd0);

  assert_ovr_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i[0] |=> !ovr_o);

  assert_udr_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i[1] |=> !udr_o);

  assert_ovr_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !err_clr_i[0]) |=> ovr_o);
endmodule

bind audio_sample_fifo afifo_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dir_rx_i    (dir_rx_i),
  .flush_i     (flush_i),
  .wr_en_i     (wr_en_i),
  .slot_req_i  (slot_req_i),
  .err_clr_i   (err_clr_i),
  .slot_data_o (slot_data_o),
  .rd_data_o   (rd_data_o),
  .level_o     (level_o),
  .req_o       (req_o),
  .ovr_o       (ovr_o),
  .udr_o       (udr_o)
);

// File: tb/sim_audio_sample_fifo.sv
module sim_audio_sample_fifo;
  localparam int CLK_P  = 10;
  localparam int WD_CYC = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dir_rx_i = 1'b0;
  logic [2:0]  thresh_i = 3'd1;
  logic        flush_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        slot_req_i = 1'b0;
  logic [3:0]  slot_idx_i = '0;
  logic [31:0] slot_data_i = '0;
  logic [31:0] slot_data_o;
  logic [2:0]  level_o;
  logic        req_o, ovr_o, udr_o;
  logic [1:0]  err_clr_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) clk_i = ~clk_i;

  audio_sample_fifo u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] d);
    @(negedge clk_i) begin wr_en_i = 1'b1; wr_data_i = d; end
    @(negedge clk_i) wr_en_i = 1'b0;
  endtask

  task automatic slot_tx(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk_i) begin slot_req_i = 1'b1; slot_idx_i = idx; end
    #1 chk(tag, slot_data_o, exp);
    @(negedge clk_i) slot_req_i = 1'b0;
  endtask

  task automatic slot_rx(input logic [31:0] d, input logic [1:0] clr);
    @(negedge clk_i) begin slot_req_i = 1'b1; slot_data_i = d; err_clr_i = clr; end
    @(negedge clk_i) begin slot_req_i = 1'b0; err_clr_i = '0; end
  endtask

  task automatic bus_read(input logic [31:0] exp, input string tag);
    @(negedge clk_i) rd_en_i = 1'b1;
    #1 chk(tag, rd_data_o, exp);
    @(negedge clk_i) rd_en_i = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk_i) flush_i = 1'b1;
    @(negedge clk_i) flush_i = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] c);
    @(negedge clk_i) err_clr_i = c;
    @(negedge clk_i) err_clr_i = '0;
  endtask

  function automatic logic [2:0] exp_lvl(input int k);
    case (k)
      0: return 3'd0;
      1, 2: return 3'd1;
      3, 4: return 3'd2;
      5, 6: return 3'd3;
      7: return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  task automatic t_reset();
    chk("R2 reset level", 32'(level_o), 32'd0);
    chk("R3 reset tx req thr1", 32'(req_o), 32'd1);
    chk("R11 reset ovr", 32'(ovr_o), 32'd0);
    chk("R11 reset udr", 32'(udr_o), 32'd0);
  endtask

  task automatic t_tx_order_full();
    @(negedge clk_i) thresh_i = 3'd4;
    #1 chk("R3 tx req empty thr8", 32'(req_o), 32'd1);
    for (int k = 0; k < 8; k++) begin
      bus_write(32'h100 + 32'(k));
      chk("R2 level after write", 32'(level_o), 32'(exp_lvl(k + 1)));
    end
    chk("R3 tx req full", 32'(req_o), 32'd0);
    bus_write(32'hDEAD);
    chk("R5 full write ignored level", 32'(level_o), 32'd5);
    for (int k = 0; k < 8; k++) slot_tx(4'(k), 32'h100 + 32'(k), "R1 tx order");
    chk("R5 no extra word stored", 32'(level_o), 32'd0);
  endtask

  task automatic t_tx_threshold();
    @(negedge clk_i) thresh_i = 3'd2;
    for (int k = 0; k < 4; k++) bus_write(32'h300 + 32'(k));
    chk("R3 tx req at thr4 count4", 32'(req_o), 32'd1);
    bus_write(32'h304);
    chk("R3 tx req thr4 count5", 32'(req_o), 32'd0);
    @(negedge clk_i) thresh_i = 3'd3;
    #1 chk("R3 tx req thr6 count5", 32'(req_o), 32'd1);
  endtask

  task automatic t_flush();
    pulse_flush();
    chk("R10 flush level", 32'(level_o), 32'd0);
    chk("R10 flush no udr", 32'(udr_o), 32'd0);
    bus_write(32'hCAFE);
    slot_tx(4'd5, 32'hCAFE, "R10 flushed data gone");
    chk("R10 level after", 32'(level_o), 32'd0);
  endtask

  task automatic t_underrun();
    @(negedge clk_i) thresh_i = 3'd1;
    bus_write(32'hA); bus_write(32'hB); bus_write(32'hC);
    slot_tx(4'd0, 32'hA, "R1 slot0");
    slot_tx(4'd1, 32'hB, "R1 slot1");
    slot_tx(4'd2, 32'hC, "R1 slot2");
    slot_tx(4'd3, 32'h0, "R7 underrun mute");
    chk("R7 udr set", 32'(udr_o), 32'd1);
    bus_write(32'hD);
    slot_tx(4'd0, 32'h0, "R8 mute slot0");
    slot_tx(4'd1, 32'h0, "R8 mute slot1");
    slot_tx(4'd2, 32'h0, "R8 mute slot2");
    chk("R8 word held while muting", 32'(level_o), 32'd1);
    slot_tx(4'd3, 32'hD, "R8 resume at missed slot");
    chk("R8 level after resume", 32'(level_o), 32'd0);
    chk("R11 udr sticky", 32'(udr_o), 32'd1);
    pulse_clr(2'b10);
    chk("R11 udr cleared", 32'(udr_o), 32'd0);
  endtask

  task automatic t_rx();
    @(negedge clk_i) begin dir_rx_i = 1'b1; thresh_i = 3'd2; end
    #1 chk("R4 rx req empty", 32'(req_o), 32'd0);
    bus_read(32'h0, "R6 empty read zero");
    chk("R6 empty read level", 32'(level_o), 32'd0);
    for (int k = 0; k < 3; k++) slot_rx(32'h200 + 32'(k), 2'b00);
    chk("R4 rx req count3 thr4", 32'(req_o), 32'd0);
    slot_rx(32'h203, 2'b00);
    chk("R4 rx req count4 thr4", 32'(req_o), 32'd1);
    for (int k = 4; k < 8; k++) slot_rx(32'h200 + 32'(k), 2'b00);
    chk("R9 rx full level", 32'(level_o), 32'd5);
    chk("R9 no ovr yet", 32'(ovr_o), 32'd0);
    slot_rx(32'hBAD, 2'b00);
    chk("R9 ovr set", 32'(ovr_o), 32'd1);
    chk("R9 level stays full", 32'(level_o), 32'd5);
    for (int k = 0; k < 8; k++) bus_read(32'h200 + 32'(k), "R6 R9 rx order");
    chk("R6 drained level", 32'(level_o), 32'd0);
    chk("R4 rx req drained", 32'(req_o), 32'd0);
    bus_read(32'h0, "R6 empty read after drain");
  endtask

  task automatic t_clear_priority();
    pulse_clr(2'b01);
    chk("R11 ovr cleared", 32'(ovr_o), 32'd0);
    for (int k = 0; k < 8; k++) slot_rx(32'h400 + 32'(k), 2'b00);
    slot_rx(32'hBAD, 2'b01);
    chk("R11 clear beats set", 32'(ovr_o), 32'd0);
    slot_rx(32'hBAD, 2'b00);
    chk("R9 ovr set again", 32'(ovr_o), 32'd1);
    repeat (2) @(negedge clk_i);
    chk("R11 ovr holds", 32'(ovr_o), 32'd1);
    chk("R11 udr unaffected", 32'(udr_o), 32'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_tx_order_full();
    t_tx_threshold();
    t_flush();
    t_underrun();
    t_rx();
    t_clear_priority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * WD_CYC);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule